// File: doc/BRIEF.md
# Burst Memory Access Frame Engine

This block turns one request frame on a 32-bit valid/ready input stream into a contiguous burst of word accesses on a simple request/acknowledge memory bus. It then answers with one response frame on a 32-bit valid/ready output stream. A request opens with four header words: a 64-bit transaction tag split over two words, a word count, and a word-aligned start address with a direction flag on top. Write requests then carry one data word per access.

The response repeats the four header words exactly as received. Read data follows in address order, one word per access; write responses carry no data. The frame closes with one status word that reports the first non-zero bus return code seen during the burst. After an error, the rest of the burst is still carried out. A zero count skips the bus entirely. The engine is ready for the next request as soon as the status word has been taken.

Top module: `bmf_engine`

## Requirements
- R1: Out of reset, `in_ready` is high and `out_valid` and `mem_req` are low. Header words are taken in this order: tag low half, tag high half, count word, address word. The count is bits [29:0] of the third word, and bits [31:30] are ignored. The start word address is bits [30:0] of the fourth word, and bit 31 selects the direction (0 = read, 1 = write).
- R2: A response frame starts with the four request header words, unchanged bit for bit, in arrival order.
- R3: A read with count C issues C bus accesses with `mem_we` low, at word addresses start, start+1, ..., start+C-1. The returned data appears in that order directly after the echoed header.
- R4: A write with count C takes C data words after the header. It writes them in order with `mem_we` high to consecutive word addresses from the start address. The response carries no data words.
- R5: The last word of every response is the status word, and `out_last` is high on it alone. Bit 0 is set when any access returned a non-zero code, bits [2:1] hold that code, and bits [31:3] are zero. A fully successful burst gives 0.
- R6: Only the first non-zero return code of a burst is kept in the status word. Later accesses of the same burst are still issued.
- R7: A count of zero issues no bus access. The response is then the four header words and a zero status word.
- R8: While `mem_req` is high and `mem_ack` is low, the request stays asserted and `mem_addr`, `mem_we` and `mem_wdata` hold their values.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values.
- R10: One cycle after the status word is accepted, `in_ready` is high again for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | DATA_W | Request stream word |
| in_valid | input | 1 | Request word valid |
| in_ready | output | 1 | Engine accepts a request word |
| out_data | output | DATA_W | Response stream word |
| out_valid | output | 1 | Response word valid |
| out_last | output | 1 | Marks the status word |
| out_ready | input | 1 | Downstream accepts a response word |
| mem_req | output | 1 | Bus access request |
| mem_we | output | 1 | 1 = write access, 0 = read access |
| mem_addr | output | ADDR_W | Word address of the access |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Access complete this cycle |
| mem_rdata | input | DATA_W | Read data, valid with `mem_ack` |
| mem_resp | input | RESP_W | Return code, valid with `mem_ack` (0 = success) |

## Verification
Response timing:
- The first echoed header word becomes valid one cycle after the clock edge that accepts the fourth request word.
- A read data word becomes valid one cycle after the edge that samples `mem_ack`.
- The status word becomes valid one cycle after the last data or header handshake.
- `in_ready` returns one cycle after the status handshake.

Because every output is a function of registered state only, the bench drives and samples on the falling edge. A word counts as transferred exactly when valid and ready are both seen there, so each comparison lands on the rising edge that moves the data. The R10 check samples one falling edge after the status word is recorded. The bus model inserts 0 to 2 wait cycles and checks that the request held still until its acknowledge.

// File: rtl/bmf_pkg.sv
package bmf_pkg;

   localparam int HDR_WORDS = 4;
   localparam int HDR_CNT_IX = 2;

   typedef enum logic [2:0] {
      ST_HDR,
      ST_ECHO,
      ST_WDATA,
      ST_BUS,
      ST_RDOUT,
      ST_STAT
   } bmf_state_e;

endpackage

// File: rtl/bmf_err_latch.sv
module bmf_err_latch #(
   parameter int RESP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              sample,
   input  logic [RESP_W-1:0] resp,
   output logic [RESP_W-1:0] code
);

   generate
      if (RESP_W < 1) begin : g_bad_resp
         $error("bmf_err_latch: RESP_W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= '0;
      end else if (clr) begin
         code <= '0;
      end else if (sample && (code == '0) && (resp != '0)) begin
         code <= resp;
      end
   end

   // R6: once a code is held, only a clear may change it
   a_r6_first_code_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (code != '0 && !clr) |=> code == $past(code));

endmodule

// File: rtl/bmf_burst_ctr.sv
module bmf_burst_ctr #(
   parameter int CNT_W  = 30,
   parameter int ADDR_W = 31
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [CNT_W-1:0]  load_cnt,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic              step,
   output logic [CNT_W-1:0]  remain,
   output logic [ADDR_W-1:0] addr,
   output logic              empty
);

   generate
      if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_width
         $error("bmf_burst_ctr: widths must be positive");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         remain <= '0;
         addr   <= '0;
      end else if (load) begin
         remain <= load_cnt;
         addr   <= load_addr;
      end else if (step) begin
         remain <= remain - CNT_W'(1);
         addr   <= addr + ADDR_W'(1);
      end
   end

   assign empty = (remain == '0);

   // R7: an access is never completed on an exhausted burst
   a_r7_step_needs_work: assert property (@(posedge clk) disable iff (!rst_n)
      step |-> remain != '0);

endmodule

// File: rtl/bmf_engine.sv
module bmf_engine
   import bmf_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 30,
   parameter int ADDR_W = 31,
   parameter int RESP_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic [DATA_W-1:0] out_data,
   output logic              out_valid,
   output logic              out_last,
   input  logic              out_ready,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   input  logic [RESP_W-1:0] mem_resp
);

   localparam int IDX_W    = $clog2(HDR_WORDS);
   localparam int STAT_PAD = DATA_W - 1 - RESP_W;

   generate
      if (ADDR_W + 1 > DATA_W) begin : g_bad_addr
         $error("bmf_engine: address field and direction bit exceed word");
      end
      if (CNT_W > DATA_W) begin : g_bad_cnt
         $error("bmf_engine: count field exceeds word");
      end
      if (STAT_PAD < 0) begin : g_bad_resp
         $error("bmf_engine: status word too narrow for response code");
      end
   endgenerate

   bmf_state_e                        state_q;
   logic [IDX_W-1:0]                  idx_q;
   logic [HDR_WORDS-1:0][DATA_W-1:0]  hdr_q;
   logic [DATA_W-1:0]                 rdata_q;
   logic [DATA_W-1:0]                 wdata_q;
   logic                              dir_q;
   logic [CNT_W-1:0]                  remain;
   logic [ADDR_W-1:0]                 cur_addr;
   logic                              empty;
   logic [RESP_W-1:0]                 err_code;

   logic in_fire, out_fire, last_idx, hdr_fire, load, step, stat_fire;

   assign in_ready  = (state_q == ST_HDR) || (state_q == ST_WDATA);
   assign in_fire   = in_valid && in_ready;
   assign out_fire  = out_valid && out_ready;
   assign last_idx  = (idx_q == IDX_W'(HDR_WORDS - 1));
   assign hdr_fire  = in_fire && (state_q == ST_HDR);
   assign load      = hdr_fire && last_idx;
   assign step      = (state_q == ST_BUS) && mem_ack;
   assign stat_fire = out_fire && (state_q == ST_STAT);

   bmf_burst_ctr #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) i_ctr (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (load),
      .load_cnt  (hdr_q[HDR_CNT_IX][CNT_W-1:0]),
      .load_addr (in_data[ADDR_W-1:0]),
      .step      (step),
      .remain    (remain),
      .addr      (cur_addr),
      .empty     (empty)
   );

   bmf_err_latch #(.RESP_W(RESP_W)) i_err (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (stat_fire),
      .sample (step),
      .resp   (mem_resp),
      .code   (err_code)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hdr_q <= '0;
         dir_q <= 1'b0;
      end else if (hdr_fire) begin
         hdr_q[idx_q] <= in_data;
         if (last_idx) dir_q <= in_data[DATA_W-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HDR;
         idx_q   <= '0;
         rdata_q <= '0;
         wdata_q <= '0;
      end else begin
         case (state_q)
            ST_HDR: if (in_fire) begin
               idx_q <= idx_q + IDX_W'(1);
               if (last_idx) state_q <= ST_ECHO;
            end
            ST_ECHO: if (out_fire) begin
               idx_q <= idx_q + IDX_W'(1);
               if (last_idx) begin
                  if (empty)      state_q <= ST_STAT;
                  else if (dir_q) state_q <= ST_WDATA;
                  else            state_q <= ST_BUS;
               end
            end
            ST_WDATA: if (in_fire) begin
               wdata_q <= in_data;
               state_q <= ST_BUS;
            end
            ST_BUS: if (mem_ack) begin
               if (!dir_q) begin
                  rdata_q <= mem_rdata;
                  state_q <= ST_RDOUT;
               end else if (remain == CNT_W'(1)) begin
                  state_q <= ST_STAT;
               end else begin
                  state_q <= ST_WDATA;
               end
            end
            ST_RDOUT: if (out_fire) begin
               state_q <= empty ? ST_STAT : ST_BUS;
            end
            ST_STAT: if (out_fire) begin
               state_q <= ST_HDR;
            end
            default: state_q <= ST_HDR;
         endcase
      end
   end

   always_comb begin
      out_valid = 1'b0;
      out_last  = 1'b0;
      out_data  = '0;
      case (state_q)
         ST_ECHO: begin
            out_valid = 1'b1;
            out_data  = hdr_q[idx_q];
         end
         ST_RDOUT: begin
            out_valid = 1'b1;
            out_data  = rdata_q;
         end
         ST_STAT: begin
            out_valid = 1'b1;
            out_last  = 1'b1;
            out_data  = {{STAT_PAD{1'b0}}, err_code, |err_code};
         end
         default: ;
      endcase
   end

   assign mem_req   = (state_q == ST_BUS);
   assign mem_we    = dir_q;
   assign mem_addr  = cur_addr;
   assign mem_wdata = wdata_q;

   // R8: a pending access holds still until acknowledged
   a_r8_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                                 && $stable(mem_wdata)));

   // R9: a stalled response word holds still
   a_r9_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   // R7: the bus is only requested while the counter has work left
   a_r7_no_req_empty: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req |-> !empty);

   // R5: the status word flag agrees with its code and the pad is zero
   a_r5_status_shape: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_last) |-> ((out_data[0] == (out_data[RESP_W:1] != '0))
                                   && (out_data[DATA_W-1:RESP_W+1] == '0)));

   // R4: input is never taken while the bus or the output is busy
   a_r4_in_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> (!mem_req && !out_valid));

endmodule

// File: tb/test_bmf_engine.sv
module test_bmf_engine;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] in_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] out_data;
   logic        out_valid, out_last;
   logic        out_ready = 1'b0;
   logic        mem_req, mem_we;
   logic [30:0] mem_addr;
   logic [31:0] mem_wdata;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic [1:0]  mem_resp = '0;

   always #2 clk = ~clk;

   bmf_engine i_bmf_engine (
      .clk(clk), .rst_n(rst_n),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .out_data(out_data), .out_valid(out_valid), .out_last(out_last), .out_ready(out_ready),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_resp(mem_resp)
   );

   int checks = 0;
   int fails = 0;

   logic [31:0] mem [0:255];
   logic [31:0] got [0:63];
   logic        got_last [0:63];
   int          got_n = 0;
   bit          frame_done = 1'b0;
   logic [30:0] acc_addr [0:63];
   logic        acc_we [0:63];
   logic [31:0] acc_wd [0:63];
   int          acc_n = 0;
   logic [31:0] rq [0:15];
   int          rq_n;
   logic [31:0] exp_w [0:63];
   int          exp_n;
   int          wait_c = 0;
   bit          pend = 1'b0;
   logic [30:0] pend_addr;
   logic        pend_we;
   logic [31:0] pend_wd;
   bit          held = 1'b0;
   logic [31:0] held_data;
   logic        held_last;

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s act=%h exp=%h", tag, act, expv);
      end
   endtask

   function automatic logic [1:0] resp_of(input logic [30:0] a);
      case (a[7:0])
         8'hF0:   return 2'd2;
         8'hF1:   return 2'd3;
         8'hF4:   return 2'd1;
         default: return 2'd0;
      endcase
   endfunction

   // bus model: 0..2 wait cycles, checks request hold (R8)
   always @(negedge clk) begin
      mem_ack = 1'b0;
      if (rst_n && mem_req) begin
         if (!pend) begin
            pend = 1'b1;
            pend_addr = mem_addr;
            pend_we = mem_we;
            pend_wd = mem_wdata;
         end else begin
            check(mem_addr == pend_addr && mem_we == pend_we && mem_wdata == pend_wd,
                  "R8 request held", {1'b0, mem_addr}, {1'b0, pend_addr});
         end
         if (wait_c == 0) begin
            mem_ack = 1'b1;
            mem_resp = resp_of(mem_addr);
            mem_rdata = mem[mem_addr[7:0]];
            if (mem_we) mem[mem_addr[7:0]] = mem_wdata;
            if (acc_n < 64) begin
               acc_addr[acc_n] = mem_addr;
               acc_we[acc_n] = mem_we;
               acc_wd[acc_n] = mem_wdata;
               acc_n++;
            end
            pend = 1'b0;
            wait_c = $urandom % 3;
         end else begin
            wait_c--;
         end
      end
   end

   // response collector with random backpressure, checks hold (R9)
   always @(negedge clk) begin
      if (rst_n) begin
         if (held) begin
            check(out_valid && out_data == held_data && out_last == held_last,
                  "R9 stalled word held", out_data, held_data);
         end
         out_ready = ($urandom % 4) != 0;
         held = out_valid && !out_ready;
         held_data = out_data;
         held_last = out_last;
         if (out_valid && out_ready && got_n < 64) begin
            got[got_n] = out_data;
            got_last[got_n] = out_last;
            got_n++;
            if (out_last) frame_done = 1'b1;
         end
      end
   end

   task automatic send_word(input logic [31:0] w);
      bit done = 1'b0;
      if ($urandom % 4 == 0) @(negedge clk);
      in_data = w;
      in_valid = 1'b1;
      while (!done) begin
         if (in_ready) done = 1'b1;
         @(negedge clk);
      end
      in_valid = 1'b0;
   endtask

   task automatic run_frame(input logic dir, input logic [29:0] size,
                            input logic [30:0] waddr, input logic [1:0] upper);
      logic [1:0]  code = 2'd0;
      logic [1:0]  r;
      logic [30:0] a;
      string       dtag;
      rq[0] = $urandom;
      rq[1] = $urandom;
      rq[2] = {upper, size};
      rq[3] = {dir, waddr};
      rq_n = 4;
      if (dir) begin
         for (int i = 0; i < int'(size); i++) rq[4 + i] = $urandom;
         rq_n = 4 + int'(size);
      end
      for (int i = 0; i < 4; i++) exp_w[i] = rq[i];
      exp_n = 4;
      for (int i = 0; i < int'(size); i++) begin
         a = waddr + 31'(i);
         r = resp_of(a);
         if (code == 2'd0) code = r;
         if (!dir) begin
            exp_w[exp_n] = mem[a[7:0]];
            exp_n++;
         end
      end
      exp_w[exp_n] = {29'd0, code, code != 2'd0};
      exp_n++;

      got_n = 0;
      frame_done = 1'b0;
      acc_n = 0;
      for (int i = 0; i < rq_n; i++) send_word(rq[i]);
      while (!frame_done) @(negedge clk);
      @(negedge clk);
      check(in_ready == 1'b1, "R10 ready after status", {31'd0, in_ready}, 32'd1);

      check(got_n == exp_n, "R5 frame length", got_n, exp_n);
      for (int i = 0; i < got_n && i < exp_n; i++) begin
         if (i < 4) check(got[i] == exp_w[i], "R2 header echo", got[i], exp_w[i]);
         else if (i == exp_n - 1) check(got[i] == exp_w[i], "R5 R6 status word", got[i], exp_w[i]);
         else check(got[i] == exp_w[i], "R3 read data", got[i], exp_w[i]);
         check(got_last[i] == (i == exp_n - 1), "R5 last marker",
               {31'd0, got_last[i]}, {31'd0, i == exp_n - 1});
      end
      dtag = (size == 0) ? "R7 access count" : "R6 all accesses issued";
      check(acc_n == int'(size), dtag, acc_n, size);
      for (int i = 0; i < acc_n && i < int'(size); i++) begin
         check(acc_addr[i] == waddr + 31'(i), "R3 access address",
               {1'b0, acc_addr[i]}, {1'b0, waddr + 31'(i)});
         check(acc_we[i] == dir, dir ? "R4 write enable" : "R3 read enable",
               {31'd0, acc_we[i]}, {31'd0, dir});
         if (dir) check(acc_wd[i] == rq[4 + i], "R4 write data", acc_wd[i], rq[4 + i]);
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R10 watchdog expired act=%0d exp=%0d", 150000, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1357));
      for (int i = 0; i < 256; i++) mem[i] = (32'(i) * 32'h01010101) ^ 32'hA500_0000;
      repeat (3) @(negedge clk);
      check(in_ready == 1'b1, "R1 reset in_ready", {31'd0, in_ready}, 32'd1);
      check(out_valid == 1'b0, "R1 reset out_valid", {31'd0, out_valid}, 32'd0);
      check(mem_req == 1'b0, "R1 reset mem_req", {31'd0, mem_req}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      run_frame(1'b0, 30'd3, 31'h10, 2'b00);            // R3 read burst
      run_frame(1'b0, 30'd0, 31'h40, 2'b00);            // R7 empty read
      run_frame(1'b1, 30'd0, 31'h41, 2'b00);            // R7 empty write
      run_frame(1'b1, 30'd4, 31'h20, 2'b11);            // R4 write, R1 unused bits
      run_frame(1'b0, 30'd4, 31'h20, 2'b00);            // R4 readback of written words
      run_frame(1'b0, 30'd3, 31'hEF, 2'b00);            // R6 first code 2 kept over 3
      run_frame(1'b1, 30'd3, 31'h1234_56F3, 2'b00);     // R6 code 1, later write done
      run_frame(1'b0, 30'd1, 31'h7FFF_FFF1, 2'b10);     // R6 single access, top address

      for (int n = 0; n < 24; n++) begin
         logic [30:0] wa;
         wa = 31'($urandom);
         run_frame(1'($urandom % 2), 30'($urandom % 7), wa, 2'($urandom % 4));
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule